// File: doc/BRIEF.md
# Accumulator Branch Condition Unit

This block decides, in the execute stage, whether a conditional branch is taken. It does not keep any stored status flags. Instead it derives four condition lines directly from the current 8-bit accumulator value. Three of the lines are fixed tests: the low bit, the high bit and the all-zero value. The fourth line is a pattern match that software sets up through a small configuration write port, as `(acc & mask) == value`.

A branch instruction picks what to test through a 3-bit operand. Bits [1:0] select a single line. Bit [2] inverts the result, so the OR form becomes a NOR form, which gives eight distinct conditions. A second operand form is also accepted. In that form a 4-bit line set selects any group of lines, the selected lines are ORed, and bit [2] of the operand still sets the polarity. The taken output is combinational and is asserted only while the branch-valid strobe is high.

Carry and parity are not tested directly. To branch on carry, software first rotates the carry into the accumulator and then tests the low or high bit.

Top module: `brcond_unit`

## Requirements
- R1: After reset the pattern mask and the pattern value are both 0. Line 3 is therefore true for every accumulator value, so a valid branch with operand 3'b011 is taken.
- R2: Line 0 is bit 0 of the accumulator. A valid branch with operand 3'b000 is taken exactly when acc[0] is 1.
- R3: Line 1 is bit 7 of the accumulator. A valid branch with operand 3'b001 is taken exactly when acc[7] is 1.
- R4: Line 2 is true when the accumulator is 8'h00. A valid branch with operand 3'b010 is taken exactly when the accumulator is zero.
- R5: Line 3 is true when `(acc & mask) == value`.
  - A write with cfg_we_i=1 and cfg_sel_i=0 loads the mask from cfg_data_i.
  - A write with cfg_we_i=1 and cfg_sel_i=1 loads the value from cfg_data_i.
  - Each write takes effect from the cycle after the clock edge that captures it.
- R6: Operand bit 2 equal to 1 inverts the selected result, giving the NOR form.
- R7: taken_o is 0 whenever br_valid_i is 0, whatever the other inputs are.
- R8: When br_set_mode_i is 1, the taken result is the OR of every line k for which br_lines_i[k] is 1, inverted when operand bit 2 is 1. Operand bits [1:0] are ignored in this form.
- R9: In the line-set form with br_lines_i equal to 4'b0000, a valid branch is not taken when operand bit 2 is 0 and is taken when operand bit 2 is 1.
- R10: taken_o follows its inputs within the same cycle, with no register delay.
- R11: While cfg_we_i is 0, the mask and value keep their contents, whatever cfg_sel_i and cfg_data_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_i | input | 8 | Current accumulator value |
| br_valid_i | input | 1 | A conditional branch is in execute this cycle |
| br_op_i | input | 3 | Bits [1:0] select a line; bit 2 selects inverted polarity |
| br_set_mode_i | input | 1 | 1 selects the line-set form |
| br_lines_i | input | 4 | Line set used in the line-set form |
| cfg_we_i | input | 1 | Pattern configuration write enable |
| cfg_sel_i | input | 1 | 0 writes the mask, 1 writes the value |
| cfg_data_i | input | 8 | Configuration write data |
| taken_o | output | 1 | Branch taken |

## Verification
The hardest situation to reach from the ports is the pattern line turning true for an accumulator that is neither zero nor all ones. Random mask and accumulator values almost never satisfy the equality by chance. To reach it, the stimulus often writes the value register with `acc & mask` for an accumulator it is about to present, and then flips single bits of that accumulator to produce near misses. The line-set form with an empty set, and writes presented while the enable is low, are driven as directed cases.

// File: rtl/brc_pkg.sv
package brc_pkg;
    localparam int NUM_LINES = 4;
    localparam int LINE_LSB  = 0;
    localparam int LINE_MSB  = 1;
    localparam int LINE_ZERO = 2;
    localparam int LINE_PAT  = 3;

    typedef enum logic {
        CFG_MASK  = 1'b0,
        CFG_VALUE = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/brc_cfg_regs.sv
module brc_cfg_regs
    import brc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] value_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] value;
    } cfg_state_t;

    cfg_state_t state_d, state_q;
    cfg_sel_e   sel;

    assign sel = cfg_sel_e'(sel_i);

    always_comb begin
        state_d = state_q;
        if (we_i) begin
            if (sel == CFG_MASK) state_d.mask  = data_i;
            else                 state_d.value = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign mask_o  = state_q.mask;
    assign value_o = state_q.value;

    // R5: a mask write lands on the next edge
    p_mask_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !sel_i) |=> (mask_o == $past(data_i)));

    // R5: a value write lands on the next edge
    p_value_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i) |=> (value_o == $past(data_i)));

    // R11: no write enable, no change
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ($stable(mask_o) && $stable(value_o)));
endmodule

// File: rtl/brc_line_eval.sv
module brc_line_eval
    import brc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LINES  = NUM_LINES
) (
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [LINES-1:0]  lines_o
);
    for (genvar k = 0; k < LINES; k++) begin : g_line
        if (k == LINE_LSB) begin : g_lsb
            assign lines_o[k] = acc_i[0];
        end else if (k == LINE_MSB) begin : g_msb
            assign lines_o[k] = acc_i[DATA_W-1];
        end else if (k == LINE_ZERO) begin : g_zero
            assign lines_o[k] = ~|acc_i;
        end else begin : g_pat
            assign lines_o[k] = ((acc_i & mask_i) == value_i);
        end
    end
endmodule

// File: rtl/brc_combine.sv
module brc_combine #(
    parameter int LINES = 4,
    parameter int SEL_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] lines_i,
    input  logic             valid_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             invert_i,
    input  logic             set_mode_i,
    input  logic [LINES-1:0] set_i,
    output logic             taken_o
);
    logic [LINES-1:0] pick;
    logic             hit;

    always_comb begin
        pick = '0;
        if (set_mode_i) pick = set_i;
        else            pick[sel_i] = 1'b1;
        hit     = |(lines_i & pick);
        taken_o = valid_i & (hit ^ invert_i);
    end
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
    import brc_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(NUM_LINES),
    localparam int OP_W  = SEL_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    acc_i,
    input  logic                 br_valid_i,
    input  logic [OP_W-1:0]      br_op_i,
    input  logic                 br_set_mode_i,
    input  logic [NUM_LINES-1:0] br_lines_i,
    input  logic                 cfg_we_i,
    input  logic                 cfg_sel_i,
    input  logic [DATA_W-1:0]    cfg_data_i,
    output logic                 taken_o
);
    logic [DATA_W-1:0]    pat_mask, pat_value;
    logic [NUM_LINES-1:0] lines;

    brc_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .data_i  (cfg_data_i),
        .mask_o  (pat_mask),
        .value_o (pat_value)
    );

    brc_line_eval #(.DATA_W(DATA_W), .LINES(NUM_LINES)) u_lines (
        .acc_i   (acc_i),
        .mask_i  (pat_mask),
        .value_i (pat_value),
        .lines_o (lines)
    );

    brc_combine #(.LINES(NUM_LINES), .SEL_W(SEL_W)) u_comb (
        .lines_i    (lines),
        .valid_i    (br_valid_i),
        .sel_i      (br_op_i[SEL_W-1:0]),
        .invert_i   (br_op_i[OP_W-1]),
        .set_mode_i (br_set_mode_i),
        .set_i      (br_lines_i),
        .taken_o    (taken_o)
    );

    // R7: no strobe, no branch
    p_idle_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid_i |-> !taken_o);

    // R2: low-bit test
    p_lsb_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_set_mode_i && br_op_i == 3'b000) |-> (taken_o == acc_i[0]));

    // R3: high-bit test
    p_msb_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_set_mode_i && br_op_i == 3'b001) |-> (taken_o == acc_i[DATA_W-1]));

    // R4: zero test
    p_zero_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_set_mode_i && br_op_i == 3'b010) |-> (taken_o == (acc_i == '0)));

    // R6: inverted zero test
    p_not_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && !br_set_mode_i && br_op_i == 3'b110) |-> (taken_o == (acc_i != '0)));

    // R9: empty line set follows polarity only
    p_empty_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid_i && br_set_mode_i && br_lines_i == '0) |-> (taken_o == br_op_i[OP_W-1]));
endmodule

// File: tb/brcond_unit_tb.sv
module brcond_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc = '0;
    logic       valid = 1'b0;
    logic [2:0] op = '0;
    logic       setm = 1'b0;
    logic [3:0] lset = '0;
    logic       we = 1'b0;
    logic       csel = 1'b0;
    logic [7:0] cdata = '0;
    logic       taken;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [7:0] m_mask = '0;
    logic [7:0] m_value = '0;

    always #10 clk = ~clk;

    brcond_unit u_dut (
        .clk(clk), .rst_n(rst_n), .acc_i(acc), .br_valid_i(valid),
        .br_op_i(op), .br_set_mode_i(setm), .br_lines_i(lset),
        .cfg_we_i(we), .cfg_sel_i(csel), .cfg_data_i(cdata), .taken_o(taken)
    );

    function automatic logic exp_taken(logic [7:0] a, logic v, logic [2:0] o,
                                       logic sm, logic [3:0] ls,
                                       logic [7:0] mk, logic [7:0] vl);
        logic [3:0] ln;
        logic [3:0] pk;
        ln[0] = a[0];
        ln[1] = a[7];
        ln[2] = (a == 8'h00);
        ln[3] = ((a & mk) == vl);
        pk = sm ? ls : (4'b0001 << o[1:0]);
        return v && ((|(ln & pk)) != o[2]);
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: taken=%0b expected=%0b (acc=%h op=%b set=%0b lines=%b)",
                     req, act, exp, acc, op, setm, lset);
        end
    endtask

    // drive at negedge, check combinational output, commit model at posedge
    task automatic step(string req, logic [7:0] a, logic v, logic [2:0] o,
                        logic sm, logic [3:0] ls,
                        logic w, logic s, logic [7:0] d);
        @(negedge clk);
        acc = a; valid = v; op = o; setm = sm; lset = ls;
        we = w; csel = s; cdata = d;
        #1;
        check(req, taken, exp_taken(a, v, o, sm, ls, m_mask, m_value));
        @(posedge clk);
        if (w) begin
            if (s) m_value = d;
            else   m_mask  = d;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset pattern line always true
        step("R1", 8'h00, 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
        step("R1", 8'hA5, 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
        step("R1", 8'hFF, 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
        // R2 / R3 / R4 / R10 fixed lines
        step("R2", 8'h03, 1, 3'b000, 0, 4'h0, 0, 0, 8'h00);
        step("R2", 8'h02, 1, 3'b000, 0, 4'h0, 0, 0, 8'h00);
        step("R3", 8'h80, 1, 3'b001, 0, 4'h0, 0, 0, 8'h00);
        step("R3", 8'h7F, 1, 3'b001, 0, 4'h0, 0, 0, 8'h00);
        step("R4", 8'h00, 1, 3'b010, 0, 4'h0, 0, 0, 8'h00);
        step("R4", 8'h01, 1, 3'b010, 0, 4'h0, 0, 0, 8'h00);
        step("R10", 8'h00, 1, 3'b010, 0, 4'h0, 0, 0, 8'h00);
        // R6 inverted forms
        step("R6", 8'h00, 1, 3'b110, 0, 4'h0, 0, 0, 8'h00);
        step("R6", 8'h01, 1, 3'b100, 0, 4'h0, 0, 0, 8'h00);
        // R7 strobe low
        step("R7", 8'h00, 0, 3'b010, 0, 4'h0, 0, 0, 8'h00);
        step("R7", 8'h00, 0, 3'b111, 1, 4'hF, 0, 0, 8'h00);
        // R5 configure mask 0xF0, value 0x50
        step("R5", 8'h5A, 1, 3'b011, 0, 4'h0, 1, 0, 8'hF0);
        step("R5", 8'h5A, 1, 3'b011, 0, 4'h0, 1, 1, 8'h50);
        step("R5", 8'h5A, 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
        step("R5", 8'h6A, 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
        // R11 writes without enable are ignored
        step("R11", 8'h5A, 1, 3'b011, 0, 4'h0, 0, 1, 8'hFF);
        step("R11", 8'h5A, 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
        step("R11", 8'h5A, 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
        // R8 line-set form, op[1:0] ignored
        step("R8", 8'h81, 1, 3'b010, 1, 4'b0011, 0, 0, 8'h00);
        step("R8", 8'h01, 1, 3'b011, 1, 4'b0110, 0, 0, 8'h00);
        step("R8", 8'h01, 1, 3'b111, 1, 4'b0110, 0, 0, 8'h00);
        // R9 empty set
        step("R9", 8'h00, 1, 3'b000, 1, 4'b0000, 0, 0, 8'h00);
        step("R9", 8'h00, 1, 3'b100, 1, 4'b0000, 0, 0, 8'h00);

        // constrained random
        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            logic [7:0] mk;
            logic [2:0] o;
            logic       sm;
            logic [3:0] ls;
            logic       v;
            string      tag;
            a  = 8'($urandom);
            o  = 3'($urandom);
            sm = (($urandom % 4) == 0);
            ls = 4'($urandom);
            v  = (($urandom % 8) != 0);
            case ($urandom % 6)
                0: a = 8'h00;
                1: a = 8'hFF;
                default: ;
            endcase
            if (!v)      tag = "R7";
            else if (sm) tag = (ls == 4'h0) ? "R9" : "R8";
            else if (o[2]) tag = "R6";
            else case (o[1:0])
                2'd0: tag = "R2";
                2'd1: tag = "R3";
                2'd2: tag = "R4";
                default: tag = "R5";
            endcase
            case ($urandom % 5)
                0: begin
                    mk = 8'($urandom);
                    step(tag, a, v, o, sm, ls, 1, 0, mk);
                end
                1: begin
                    step(tag, a, v, o, sm, ls, 1, 1, a & m_mask);
                    step("R5", a, 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
                    step("R5", a ^ (8'h01 << ($urandom % 8)), 1, 3'b011, 0, 4'h0, 0, 0, 8'h00);
                end
                2: step(tag, a, v, o, sm, ls, 0, 1'($urandom), 8'($urandom));
                default: step(tag, a, v, o, sm, ls, 0, 0, 8'h00);
            endcase
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule